// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block sits behind a byte-wide register port and carries one command from a host into a local buffer and one response back out, for whichever locality is currently active. The host first writes the ready-request bit of the status register, then streams command bytes into the data window. The block reads the total length from the big-endian field in the first ten bytes of the command and keeps its "more data expected" flag set until that many bytes have arrived.

A write of the start bit then hands the command to an execution stub. The stub waits for a delay that the host sets through a port, then offers a canned response. That response carries a fixed header with the command's length, and its body is the bitwise inverse of the command's body bytes. While a command goes in or a response comes out, a 16-bit transfer allowance tells the host how many bytes it may move before it must poll again.

Accesses tagged with any locality other than the active one have no effect and read back as 0xFF.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the block is idle. The status byte (offset 0x018) reads 0x80, the transfer allowance (offsets 0x019 low byte, 0x01A high byte) reads 0, and a data-window read (offset 0x024) returns 0xFF.
- R2: A write to the status byte with bit 6 set aborts whatever is in progress, in any state. The block returns to ready: status reads 0xC8 (bit 7 valid, bit 6 ready, bit 3 expect), the allowance reads DEPTH, and no response bytes remain.
- R3: Bit 3 (expect) stays 1 until N bytes have been written, then clears, and status reads 0x80. N is the big-endian length held in command bytes 2 to 5, with bytes 2 to 5 treated as MSB first, and clamped to the range [10, DEPTH].
- R4: The allowance is little-endian. It equals DEPTH minus the bytes written while expect is 1, and N minus the bytes read while a response is available. It is 0 in all other states.
- R5: Data-window writes made while expect is 0 are discarded and leave status and allowance unchanged.
- R6: A status write with bit 5 set, after a complete command, starts execution. Status reads 0x80 for exec_delay+1 cycles after the start edge, then reads 0x90 (bit 4 data available).
- R7: A start write while expect is still 1 is ignored. Status stays 0x88 and the allowance is unchanged.
- R8: Response byte i reads as follows: byte 0 is 0x80, byte 1 is 0xC4, bytes 2 to 5 hold N big-endian, bytes 6 to 9 are 0, and every later byte is the inverse of command byte i. Each data-window read pops one byte.
- R9: Once all N response bytes have been read, bit 4 reads 0, status reads 0x80, and further data-window reads return 0xFF.
- R10: Accesses whose locality differs from active_loc read 0xFF and change nothing. Offsets other than 0x018, 0x019, 0x01A and 0x024 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per byte |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_loc | input | 3 | Locality of the access |
| bus_addr | input | 12 | Byte offset within the locality window |
| bus_wdata | input | 8 | Write data |
| active_loc | input | 3 | Locality that currently owns the block |
| exec_delay | input | 16 | Stub execution delay in cycles |
| bus_rdata | output | 8 | Read data, valid from the edge after the read strobe |

## Verification
The bench sweeps length fields below the header size, exactly at it, in between, at the buffer depth and above it. For each one it checks the allowance before every byte in both directions. A design with an off-by-one in the length target or the clamp would either clear expect one byte early, or keep expect set with no further bytes coming, and the allowance would drift from DEPTH minus the count. The bench also aims a start write at a half-written command; a design that ignored the expect guard would start execution early and show 0x80 instead of 0x88. The start-to-available latency is checked on the exact cycle, and aborts are tried both mid-receive and mid-response, where a stale read pointer would leave data-available set.

// File: rtl/cmdrsp_pkg.sv
// Shared types and register offsets for the command/response engine.
// Assumes byte-wide register accesses; offsets are relative to a locality window.
package cmdrsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_RECV,
        ST_EXEC,
        ST_COMPL
    } crf_state_e;

    localparam logic [11:0] OFF_STS      = 12'h018;
    localparam logic [11:0] OFF_BURST_LO = 12'h019;
    localparam logic [11:0] OFF_BURST_HI = 12'h01A;
    localparam logic [11:0] OFF_FIFO     = 12'h024;

    localparam int BIT_VALID  = 7;
    localparam int BIT_RDY    = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_AVAIL  = 4;
    localparam int BIT_EXPECT = 3;
endpackage

// File: rtl/cmdrsp_buf.sv
// Command byte store: one synchronous write port, one combinational read port.
// Assumes the caller keeps waddr below DEPTH; contents are not reset.
module cmdrsp_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store an accepted command byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cmdrsp_len.sv
// Captures the big-endian length from command bytes 2..5 and clamps it to [HDR, DEPTH].
// Assumes wpos is the index of the byte being accepted on this cycle.
module cmdrsp_len #(
    parameter int DEPTH = 64,
    parameter int HDR   = 10,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [CNT_W-1:0] wpos,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] target
);
    logic [31:0] len_q;
    logic        in_field;

    assign in_field = (wpos >= CNT_W'(2)) && (wpos <= CNT_W'(5));

    // Shift header length bytes in, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      len_q <= '0;
        else if (we && in_field) len_q <= {len_q[23:0], wdata};
    end

    // Clamp the captured length into the buffer's usable range.
    always_comb begin
        if (len_q < 32'(HDR))        target = CNT_W'(HDR);
        else if (len_q > 32'(DEPTH)) target = CNT_W'(DEPTH);
        else                         target = len_q[CNT_W-1:0];
    end
endmodule

// File: rtl/cmdrsp_ctrl.sv
// Sequencer: idle, ready, receiving, executing, completing; owns write/read counts,
// the stub delay, and the expect/available flags and transfer allowance.
// Assumes the strobes are already qualified by locality and offset.
module cmdrsp_ctrl
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DLY_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fifo,
    input  logic             rd_fifo,
    input  logic             sts_rdy,
    input  logic             sts_go,
    input  logic [DLY_W-1:0] exec_delay,
    input  logic [CNT_W-1:0] target,
    output crf_state_e       state,
    output logic [CNT_W-1:0] wcnt,
    output logic [CNT_W-1:0] rcnt,
    output logic             expect_o,
    output logic             avail_o,
    output logic             accept_w,
    output logic [15:0]      burst
);
    logic [DLY_W-1:0] dly;

    // Flags derived from state and counts.
    assign expect_o = (state == ST_READY) ||
                      ((state == ST_RECV) && ((wcnt < CNT_W'(6)) || (wcnt < target)));
    assign avail_o  = (state == ST_COMPL) && (rcnt < target);
    assign accept_w = wr_fifo && expect_o;

    // State and counter updates; abort has priority over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            rcnt  <= '0;
            dly   <= '0;
        end else if (sts_rdy) begin
            state <= ST_READY;
            wcnt  <= '0;
            rcnt  <= '0;
            dly   <= '0;
        end else begin
            case (state)
                ST_READY: if (accept_w) begin
                    state <= ST_RECV;
                    wcnt  <= wcnt + 1'b1;
                end
                ST_RECV: begin
                    if (accept_w) wcnt <= wcnt + 1'b1;
                    else if (sts_go && !expect_o) begin
                        state <= ST_EXEC;
                        dly   <= exec_delay;
                    end
                end
                ST_EXEC: begin
                    if (dly == '0) state <= ST_COMPL;
                    else           dly   <= dly - 1'b1;
                end
                ST_COMPL: if (rd_fifo && avail_o) rcnt <= rcnt + 1'b1;
                default: ;
            endcase
        end
    end

    // Transfer allowance: free space while taking bytes, remaining while giving them.
    always_comb begin
        if (expect_o)     burst = 16'(DEPTH) - 16'(wcnt);
        else if (avail_o) burst = 16'(target) - 16'(rcnt);
        else              burst = '0;
    end
endmodule

// File: rtl/cmdrsp_engine.sv
// Top: locality and offset decode, response byte generation, registered read data.
// Assumes one byte access per bus_valid cycle; read data appears after the next edge.
module cmdrsp_engine
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HDR   = 10,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_loc,
    input  logic [11:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic [2:0]       active_loc,
    input  logic [DLY_W-1:0] exec_delay,
    output logic [7:0]       bus_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);

    logic             hit, wr_sts, sts_rdy, sts_go, wr_fifo, rd_fifo;
    crf_state_e       state;
    logic [CNT_W-1:0] wcnt, rcnt, target;
    logic             expect_w, avail_w, accept_w;
    logic [15:0]      burst;
    logic [7:0]       buf_rdata, rsp_byte, sts_byte, rd_byte;
    logic [31:0]      len32;

    // Access qualification.
    assign hit     = bus_valid && (bus_loc == active_loc);
    assign wr_sts  = hit && bus_write && (bus_addr == OFF_STS);
    assign sts_rdy = wr_sts && bus_wdata[BIT_RDY];
    assign sts_go  = wr_sts && bus_wdata[BIT_GO];
    assign wr_fifo = hit && bus_write && (bus_addr == OFF_FIFO);
    assign rd_fifo = hit && !bus_write && (bus_addr == OFF_FIFO);

    cmdrsp_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_fifo(wr_fifo), .rd_fifo(rd_fifo),
        .sts_rdy(sts_rdy), .sts_go(sts_go), .exec_delay(exec_delay),
        .target(target), .state(state), .wcnt(wcnt), .rcnt(rcnt),
        .expect_o(expect_w), .avail_o(avail_w), .accept_w(accept_w), .burst(burst)
    );

    cmdrsp_len #(.DEPTH(DEPTH), .HDR(HDR), .CNT_W(CNT_W)) i_len (
        .clk(clk), .rst_n(rst_n), .clr(sts_rdy), .we(accept_w),
        .wpos(wcnt), .wdata(bus_wdata), .target(target)
    );

    cmdrsp_buf #(.DEPTH(DEPTH), .AW(AW)) i_buf (
        .clk(clk), .we(accept_w), .waddr(wcnt[AW-1:0]), .wdata(bus_wdata),
        .raddr(rcnt[AW-1:0]), .rdata(buf_rdata)
    );

    assign len32 = 32'(target);

    // Canned response: fixed header carrying the length, body is the inverted command.
    always_comb begin
        case (rcnt)
            CNT_W'(0): rsp_byte = 8'h80;
            CNT_W'(1): rsp_byte = 8'hC4;
            CNT_W'(2): rsp_byte = len32[31:24];
            CNT_W'(3): rsp_byte = len32[23:16];
            CNT_W'(4): rsp_byte = len32[15:8];
            CNT_W'(5): rsp_byte = len32[7:0];
            CNT_W'(6), CNT_W'(7), CNT_W'(8), CNT_W'(9): rsp_byte = 8'h00;
            default:   rsp_byte = ~buf_rdata;
        endcase
    end

    assign sts_byte = {1'b1, (state == ST_READY), 1'b0, avail_w, expect_w, 3'b000};

    // Read multiplexer for the active locality's window.
    always_comb begin
        if (!hit) rd_byte = 8'hFF;
        else begin
            case (bus_addr)
                OFF_STS:      rd_byte = sts_byte;
                OFF_BURST_LO: rd_byte = burst[7:0];
                OFF_BURST_HI: rd_byte = burst[15:8];
                OFF_FIFO:     rd_byte = avail_w ? rsp_byte : 8'hFF;
                default:      rd_byte = 8'hFF;
            endcase
        end
    end

    // Register read data on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_rdata <= 8'hFF;
        else if (bus_valid && !bus_write) bus_rdata <= rd_byte;
    end
endmodule

// File: rtl/cmdrsp_engine_chk.sv
// Property checker for cmdrsp_engine, attached by bind below.
// Assumes it sees the top's internal strobes and sequencer state.
module cmdrsp_engine_chk
    import cmdrsp_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             sts_rdy,
    input logic             sts_go,
    input crf_state_e       state,
    input logic [CNT_W-1:0] wcnt,
    input logic [CNT_W-1:0] rcnt,
    input logic             expect_w,
    input logic             avail_w,
    input logic [15:0]      burst
);
    AST_ABORT_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdy |=> (state == ST_READY) && (wcnt == '0) && (rcnt == '0)); // R2
    AST_EXPECT_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        expect_w |-> (state == ST_READY || state == ST_RECV)); // R3
    AST_BURST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_EXEC) |-> (burst == 16'd0)); // R4
    AST_EXEC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !sts_rdy) |=> (state == ST_EXEC || state == ST_COMPL)); // R6
    AST_GO_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_go && !sts_rdy && expect_w) |=> (state != ST_EXEC)); // R7
    AST_AVAIL_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        avail_w |-> (state == ST_COMPL)); // R9
    AST_FOREIGN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(wcnt) && $stable(rcnt))); // R10
endmodule

bind cmdrsp_engine cmdrsp_engine_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .hit(hit), .sts_rdy(sts_rdy), .sts_go(sts_go),
    .state(state), .wcnt(wcnt), .rcnt(rcnt), .expect_w(expect_w),
    .avail_w(avail_w), .burst(burst)
);

// File: tb/test_cmdrsp_engine.sv
// Self-checking bench: sweeps command lengths, aborts, foreign accesses.
module test_cmdrsp_engine;
    localparam int DEPTH = 64;
    localparam int HDR   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_loc = 3'd0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [2:0]  active_loc = 3'd0;
    logic [15:0] exec_delay = '0;
    logic [7:0]  bus_rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] cmd [DEPTH];

    cmdrsp_engine #(.DEPTH(DEPTH), .HDR(HDR), .DLY_W(16)) i_cmdrsp_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_loc(bus_loc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .active_loc(active_loc), .exec_delay(exec_delay), .bus_rdata(bus_rdata)
    );

    always #10ns clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] loc, input logic [11:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_loc = loc; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] loc, input logic [11:0] a, output int d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_loc = loc; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        d = int'(bus_rdata);
    endtask

    function automatic int clamp_len(input int lf);
        if (lf < HDR) return HDR;
        if (lf > DEPTH) return DEPTH;
        return lf;
    endfunction

    function automatic int rsp_exp(input int i, input int n);
        if (i == 0) return 8'h80;
        if (i == 1) return 8'hC4;
        if (i >= 2 && i <= 5) return (n >> (8 * (5 - i))) & 8'hFF;
        if (i <= 9) return 0;
        return (~int'(cmd[i])) & 8'hFF;
    endfunction

    // Sends a full command whose length field is lf, checking flags before each byte.
    task automatic send_cmd(input int lf);
        int n, v;
        n = clamp_len(lf);
        for (int i = 0; i < n; i++) begin
            if (i >= 2 && i <= 5) cmd[i] = 8'((lf >> (8 * (5 - i))) & 8'hFF);
            else                  cmd[i] = 8'(i * 7 + n);
            bus_rd(3'd0, 12'h019, v); chk("R4 burst while receiving", v, DEPTH - i);
            bus_rd(3'd0, 12'h018, v); chk("R3 expect set", v, (i == 0) ? 8'hC8 : 8'h88);
            if (i == 3) begin
                bus_wr(3'd0, 12'h018, 8'h20);
                bus_rd(3'd0, 12'h018, v); chk("R7 early go ignored status", v, 8'h88);
                bus_rd(3'd0, 12'h019, v); chk("R7 early go ignored burst", v, DEPTH - 3);
            end
            bus_wr(3'd0, 12'h024, cmd[i]);
        end
        bus_rd(3'd0, 12'h018, v); chk("R3 expect clear", v, 8'h80);
        bus_rd(3'd0, 12'h019, v); chk("R4 burst zero when complete", v, 0);
        bus_wr(3'd0, 12'h024, 8'h5A);
        bus_rd(3'd0, 12'h018, v); chk("R5 extra write status", v, 8'h80);
        bus_rd(3'd0, 12'h019, v); chk("R5 extra write burst", v, 0);
    endtask

    // Starts execution and checks the exact cycle data becomes available.
    task automatic go_wait(input int d);
        int v;
        exec_delay = 16'(d);
        bus_wr(3'd0, 12'h018, 8'h20);
        repeat (d) @(negedge clk);
        bus_rd(3'd0, 12'h018, v); chk("R6 executing status", v, 8'h80);
        bus_rd(3'd0, 12'h018, v); chk("R6 response ready status", v, 8'h90);
    endtask

    // Reads nrd response bytes of an n-byte response.
    task automatic read_rsp(input int n, input int nrd);
        int v;
        for (int i = 0; i < nrd; i++) begin
            bus_rd(3'd0, 12'h019, v); chk("R4 burst while completing", v, n - i);
            bus_rd(3'd0, 12'h01A, v); chk("R4 burst high byte", v, 0);
            bus_rd(3'd0, 12'h024, v); chk("R8 response byte", v, rsp_exp(i, n));
        end
    endtask

    task automatic abort_chk(input string tag);
        int v;
        bus_wr(3'd0, 12'h018, 8'h40);
        bus_rd(3'd0, 12'h018, v); chk({tag, " status"}, v, 8'hC8);
        bus_rd(3'd0, 12'h019, v); chk({tag, " burst"}, v, DEPTH);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int v;
        int lens [7] = '{10, 11, 17, 33, 64, 5, 200};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        bus_rd(3'd0, 12'h018, v); chk("R1 reset status", v, 8'h80);
        bus_rd(3'd0, 12'h019, v); chk("R1 reset burst low", v, 0);
        bus_rd(3'd0, 12'h01A, v); chk("R1 reset burst high", v, 0);
        bus_rd(3'd0, 12'h024, v); chk("R1 reset data read", v, 8'hFF);

        bus_rd(3'd2, 12'h018, v); chk("R10 foreign read", v, 8'hFF);
        bus_wr(3'd2, 12'h018, 8'h40);
        bus_rd(3'd0, 12'h018, v); chk("R10 foreign write ignored", v, 8'h80);
        bus_rd(3'd0, 12'h030, v); chk("R10 unmapped offset", v, 8'hFF);

        foreach (lens[k]) begin
            int n;
            n = clamp_len(lens[k]);
            abort_chk("R2 ready");
            send_cmd(lens[k]);
            go_wait(n % 5);
            read_rsp(n, n);
            bus_rd(3'd0, 12'h018, v); chk("R9 avail clear", v, 8'h80);
            bus_rd(3'd0, 12'h024, v); chk("R9 drained read", v, 8'hFF);
            bus_rd(3'd0, 12'h019, v); chk("R9 drained burst", v, 0);
        end

        // Abort mid-receive.
        abort_chk("R2 ready");
        for (int i = 0; i < 4; i++) bus_wr(3'd0, 12'h024, 8'(i));
        abort_chk("R2 abort receiving");

        // Abort mid-response.
        send_cmd(12);
        go_wait(2);
        read_rsp(12, 5);
        abort_chk("R2 abort completing");
        bus_rd(3'd0, 12'h024, v); chk("R2 no data after abort", v, 8'hFF);

        // Foreign access during receive changes nothing.
        bus_wr(3'd0, 12'h024, 8'h00);
        bus_wr(3'd1, 12'h024, 8'h11);
        bus_rd(3'd1, 12'h019, v); chk("R10 foreign burst read", v, 8'hFF);
        bus_rd(3'd0, 12'h019, v); chk("R10 foreign write not counted", v, DEPTH - 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule